// File: doc/BRIEF.md
# Thresholded Event Counter

This block is one counter slot of a performance monitor. Each clock it receives a multi-bit event amount, such as the number of stall slots that occurred in that cycle. It decides from a programmable threshold condition whether that cycle counts. A passing cycle adds either 1 or the full amount to a wide counter. Which of the two is added depends on a mode bit.

Software-side configuration reaches the slot through a parallel write port. The port carries a threshold and a 3-bit control field. The upper two control bits pick the comparison and the lowest bit picks the count mode. A threshold of zero turns the comparison off, and the slot then accumulates the raw amount.

The maximum threshold follows from a build parameter W. It is reported both as a value and as a 4-bit field of an identification word. Writes above that maximum saturate. A W of zero means the slot has no threshold logic. The counter wraps on carry-out and raises a sticky overflow flag.

Top module: `thr_evt_counter`

## Requirements
- R1: After reset the counter, the overflow flag, the stored threshold and the stored control field all read zero.
- R2: While the stored threshold is 0, every enabled cycle adds the raw event amount, whatever the control field holds.
- R3: With a nonzero threshold, control bits [2:1] choose an unsigned test of the event amount against the threshold: 00 not-equal, 01 equal, 10 greater-or-equal, 11 less-than. A cycle that fails the test adds nothing.
- R4: Control bit [0] set makes a passing cycle add exactly 1. Control bit [0] clear makes it add that cycle's event amount.
- R5: A threshold write above the maximum 2^W-1 stores the maximum. The maximum is reported on `max_thr_o`.
- R6: `id_o[23:20]` reports W, and all other bits of `id_o` are zero.
- R7: With W = 0 the maximum reads 0, the stored threshold always reads 0, and the counter accumulates raw amounts.
- R8: A configuration write takes effect from the next cycle. The event sampled in the write cycle is judged by the old settings.
- R9: While the enable is low the counter holds its value.
- R10: A carry out of the counter wraps it modulo 2^CNT_W and sets `ovf_o`. The flag stays set until `ovf_clr_i` is pulsed. A new carry in the same cycle as the clear pulse leaves the flag set.
- R11: `cnt_clr_i` zeroes the counter on the next edge, over any increment, and leaves `ovf_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_thr_i | input | THR_W | Threshold to write |
| cfg_ctl_i | input | 3 | Control field to write: [2:1] comparison, [0] count mode |
| cnt_en_i | input | 1 | Counter enable |
| cnt_clr_i | input | 1 | Synchronous counter clear |
| ovf_clr_i | input | 1 | Write-one-to-clear for the overflow flag |
| evt_i | input | EVT_W | Event amount of this cycle |
| thr_o | output | THR_W | Stored (saturated) threshold |
| ctl_o | output | 3 | Stored control field |
| max_thr_o | output | THR_W | Largest storable threshold |
| id_o | output | 32 | Identification word, W in [23:20] |
| cnt_o | output | CNT_W | Counter value |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The four comparisons are each driven with one amount equal to the threshold and one on each side of it. This shows a swapped or off-by-one comparator, and also shows a pass that adds 1 instead of the raw amount. Zero threshold is tried with a control field that would reject the event, to show that the field is ignored. A second slot built with W = 0 receives the same stimulus throughout and must always count raw. Runs of maximal amounts drive the counter through wrap, once with no clear and once with the clear pulse held, to tell a flag that sets and holds from one that is lost to a simultaneous clear.

// File: rtl/thr_evt_pkg.sv
package thr_evt_pkg;
  typedef enum logic [1:0] {
    CMP_NE = 2'b00,
    CMP_EQ = 2'b01,
    CMP_GE = 2'b10,
    CMP_LT = 2'b11
  } cmp_sel_e;

  typedef struct packed {
    cmp_sel_e sel;
    logic     unit_step;
  } thr_ctl_t;
endpackage

// File: rtl/thr_cfg_reg.sv
module thr_cfg_reg
  import thr_evt_pkg::*;
#(
  parameter int THR_W = 12,
  parameter int THW   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic [2:0]       ctl_i,
  output logic [THR_W-1:0] thr_o,
  output thr_ctl_t         ctl_o,
  output logic [THR_W-1:0] max_o
);
  localparam logic [THR_W-1:0] MaxThr = (THW == 0) ? '0 : THR_W'((32'd1 << THW) - 32'd1);

  logic [THR_W-1:0] thr_q;
  thr_ctl_t         ctl_q;
  logic [THR_W-1:0] thr_sat;

  // saturate rather than truncate
  assign thr_sat = (thr_i > MaxThr) ? MaxThr : thr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q <= '0;
      ctl_q <= '0;
    end else if (we_i) begin
      thr_q <= thr_sat;
      ctl_q <= thr_ctl_t'(ctl_i);
    end
  end

  assign thr_o = thr_q;
  assign ctl_o = ctl_q;
  assign max_o = MaxThr;
endmodule

// File: rtl/thr_qualify.sv
module thr_qualify
  import thr_evt_pkg::*;
#(
  parameter int EVT_W = 8,
  parameter int THR_W = 12
) (
  input  logic [EVT_W-1:0] evt_i,
  input  logic [THR_W-1:0] thr_i,
  input  thr_ctl_t         ctl_i,
  output logic [EVT_W-1:0] inc_o
);
  localparam int CW = (EVT_W > THR_W) ? EVT_W : THR_W;

  logic [CW-1:0] evt_x, thr_x;
  logic          pass;

  assign evt_x = CW'(evt_i);
  assign thr_x = CW'(thr_i);

  always_comb begin
    unique case (ctl_i.sel)
      CMP_NE:  pass = (evt_x != thr_x);
      CMP_EQ:  pass = (evt_x == thr_x);
      CMP_GE:  pass = (evt_x >= thr_x);
      default: pass = (evt_x <  thr_x);
    endcase
  end

  always_comb begin
    if (thr_i == '0)    inc_o = evt_i;
    else if (!pass)     inc_o = '0;
    else if (ctl_i.unit_step) inc_o = EVT_W'(1);
    else                inc_o = evt_i;
  end
endmodule

// File: rtl/thr_accum.sv
module thr_accum #(
  parameter int CNT_W = 64,
  parameter int EVT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             ovf_clr_i,
  input  logic [EVT_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic [CNT_W:0]   sum;
  logic             carry;

  assign sum   = {1'b0, cnt_q} + (CNT_W+1)'(inc_i);
  assign carry = en_i && !clr_i && sum[CNT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (clr_i)     cnt_q <= '0;
      else if (en_i) cnt_q <= sum[CNT_W-1:0];
      // a new carry outranks the clear pulse
      if (carry)          ovf_q <= 1'b1;
      else if (ovf_clr_i) ovf_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/thr_evt_counter.sv
module thr_evt_counter
  import thr_evt_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int EVT_W = 8,
  parameter int THR_W = 12,
  parameter int THW   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [THR_W-1:0] cfg_thr_i,
  input  logic [2:0]       cfg_ctl_i,
  input  logic             cnt_en_i,
  input  logic             cnt_clr_i,
  input  logic             ovf_clr_i,
  input  logic [EVT_W-1:0] evt_i,
  output logic [THR_W-1:0] thr_o,
  output logic [2:0]       ctl_o,
  output logic [THR_W-1:0] max_thr_o,
  output logic [31:0]      id_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [3:0] ThwField = 4'(THW);

  thr_ctl_t         ctl_q;
  logic [EVT_W-1:0] inc;

  thr_cfg_reg #(.THR_W(THR_W), .THW(THW)) i_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (cfg_we_i),
    .thr_i (cfg_thr_i),
    .ctl_i (cfg_ctl_i),
    .thr_o (thr_o),
    .ctl_o (ctl_q),
    .max_o (max_thr_o)
  );

  thr_qualify #(.EVT_W(EVT_W), .THR_W(THR_W)) i_qual (
    .evt_i(evt_i),
    .thr_i(thr_o),
    .ctl_i(ctl_q),
    .inc_o(inc)
  );

  thr_accum #(.CNT_W(CNT_W), .EVT_W(EVT_W)) i_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (cnt_en_i),
    .clr_i    (cnt_clr_i),
    .ovf_clr_i(ovf_clr_i),
    .inc_i    (inc),
    .cnt_o    (cnt_o),
    .ovf_o    (ovf_o)
  );

  assign ctl_o = ctl_q;
  assign id_o  = {8'd0, ThwField, 20'd0};
endmodule

// File: rtl/thr_evt_counter_chk.sv
module thr_evt_counter_chk #(
  parameter int CNT_W = 64,
  parameter int THR_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cnt_en_i,
  input logic             cnt_clr_i,
  input logic             ovf_clr_i,
  input logic [2:0]       ctl_o,
  input logic [THR_W-1:0] thr_o,
  input logic [THR_W-1:0] max_thr_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic             ovf_o
);
  assert_thr_in_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_o <= max_thr_o);

  assert_hold_when_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_en_i && !cnt_clr_i) |=> $stable(cnt_o));

  assert_unit_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !cnt_clr_i && ctl_o[0] && thr_o != '0)
      |=> (CNT_W'(cnt_o - $past(cnt_o)) <= CNT_W'(1)));

  assert_ovf_on_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> (cnt_o < $past(cnt_o)));

  assert_ovf_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);

  assert_clear_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_i |=> (cnt_o == '0));
endmodule

bind thr_evt_counter thr_evt_counter_chk #(.CNT_W(CNT_W), .THR_W(THR_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cnt_en_i (cnt_en_i),
  .cnt_clr_i(cnt_clr_i),
  .ovf_clr_i(ovf_clr_i),
  .ctl_o    (ctl_o),
  .thr_o    (thr_o),
  .max_thr_o(max_thr_o),
  .cnt_o    (cnt_o),
  .ovf_o    (ovf_o)
);

// File: tb/test_thr_evt_counter.sv
module test_thr_evt_counter;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int EVT_W = 8;
  localparam int THR_W = 12;
  localparam int THW   = 8;
  localparam int MAXT  = 255;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cfg_we_i = 1'b0;
  logic [THR_W-1:0] cfg_thr_i = '0;
  logic [2:0]       cfg_ctl_i = '0;
  logic             cnt_en_i = 1'b0;
  logic             cnt_clr_i = 1'b0;
  logic             ovf_clr_i = 1'b0;
  logic [EVT_W-1:0] evt_i = '0;

  logic [THR_W-1:0] thr_o, thr2_o, max_o, max2_o;
  logic [2:0]       ctl_o, ctl2_o;
  logic [31:0]      id_o, id2_o;
  logic [CNT_W-1:0] cnt_o, cnt2_o;
  logic             ovf_o, ovf2_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  thr_evt_counter #(.CNT_W(CNT_W), .EVT_W(EVT_W), .THR_W(THR_W), .THW(THW)) i_thr_evt_counter (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_thr_i, .cfg_ctl_i, .cnt_en_i, .cnt_clr_i,
    .ovf_clr_i, .evt_i, .thr_o, .ctl_o, .max_thr_o(max_o), .id_o, .cnt_o, .ovf_o);

  // slot without threshold logic (R7), fed the same stimulus
  thr_evt_counter #(.CNT_W(CNT_W), .EVT_W(EVT_W), .THR_W(THR_W), .THW(0)) i_thr_evt_counter_absent (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_thr_i, .cfg_ctl_i, .cnt_en_i, .cnt_clr_i,
    .ovf_clr_i, .evt_i, .thr_o(thr2_o), .ctl_o(ctl2_o), .max_thr_o(max2_o),
    .id_o(id2_o), .cnt_o(cnt2_o), .ovf_o(ovf2_o));

  typedef struct {
    int cnt; bit ovf; int thr; int ctl; int cnt2; bit ovf2; int req;
  } exp_t;
  exp_t q[$];

  int total = 0, bad = 0;
  int m_thr = 0, m_ctl = 0, m_cnt = 0, m2_cnt = 0;
  bit m_ovf = 0, m2_ovf = 0;

  task automatic chk(input bit ok, input int req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: drive one cycle, advance the model, push the expected result
  task automatic cyc(input bit we, input int thr, input int ctl, input int evt,
                     input bit en, input bit clr, input bit oclr, input int req);
    bit pass;
    int add, sum;
    exp_t e;
    @(negedge clk_i);
    cfg_we_i = we; cfg_thr_i = THR_W'(thr); cfg_ctl_i = 3'(ctl);
    evt_i = EVT_W'(evt); cnt_en_i = en; cnt_clr_i = clr; ovf_clr_i = oclr;
    // thresholded slot
    case ((m_ctl >> 1) & 3)
      0: pass = (evt != m_thr);
      1: pass = (evt == m_thr);
      2: pass = (evt >= m_thr);
      default: pass = (evt < m_thr);
    endcase
    if (m_thr == 0) add = evt;
    else if (!pass) add = 0;
    else add = (m_ctl & 1) ? 1 : evt;
    if (oclr) m_ovf = 0;
    if (clr) m_cnt = 0;
    else if (en) begin
      sum = m_cnt + add;
      if (sum >= 65536) m_ovf = 1;
      m_cnt = sum % 65536;
    end
    // absent slot counts raw
    if (oclr) m2_ovf = 0;
    if (clr) m2_cnt = 0;
    else if (en) begin
      sum = m2_cnt + evt;
      if (sum >= 65536) m2_ovf = 1;
      m2_cnt = sum % 65536;
    end
    if (we) begin
      m_thr = (thr > MAXT) ? MAXT : thr;
      m_ctl = ctl;
    end
    e.cnt = m_cnt; e.ovf = m_ovf; e.thr = m_thr; e.ctl = m_ctl;
    e.cnt2 = m2_cnt; e.ovf2 = m2_ovf; e.req = req;
    q.push_back(e);
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(int'(cnt_o) == e.cnt, e.req, "cnt", int'(cnt_o), e.cnt);
        chk(ovf_o == e.ovf, e.req, "ovf", int'(ovf_o), int'(e.ovf));
        chk(int'(thr_o) == e.thr, e.req, "thr", int'(thr_o), e.thr);
        chk(int'(ctl_o) == e.ctl, e.req, "ctl", int'(ctl_o), e.ctl);
        // R7: absent slot
        chk(int'(cnt2_o) == e.cnt2, 7, "absent cnt", int'(cnt2_o), e.cnt2);
        chk(ovf2_o == e.ovf2, 7, "absent ovf", int'(ovf2_o), int'(e.ovf2));
        chk(thr2_o == '0, 7, "absent thr", int'(thr2_o), 0);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    // R1: reset state
    chk(cnt_o == '0 && ovf_o == 1'b0, 1, "reset cnt/ovf", int'(cnt_o), 0);
    chk(thr_o == '0 && ctl_o == '0, 1, "reset cfg", int'(thr_o), 0);
    rst_ni = 1'b1;
    // R5, R6, R7: static reports
    chk(int'(max_o) == MAXT, 5, "max", int'(max_o), MAXT);
    chk(id_o == 32'h0080_0000, 6, "id", int'(id_o), 32'h0080_0000);
    chk(max2_o == '0, 7, "absent max", int'(max2_o), 0);
    chk(id2_o == 32'h0, 6, "absent id", int'(id2_o), 0);

    // R2: threshold 0, control would reject but is ignored
    cyc(1, 0, 3'b011, 0, 0, 0, 0, 2);
    cyc(0, 0, 0, 5, 1, 0, 0, 2);
    cyc(0, 0, 0, 0, 1, 0, 0, 2);
    cyc(0, 0, 0, 9, 1, 0, 0, 2);
    // R8: write ge/unit thr=2 while evt=1 is judged by old config
    cyc(1, 2, 3'b101, 1, 1, 0, 0, 8);
    cyc(0, 0, 0, 1, 1, 0, 0, 8);
    cyc(0, 0, 0, 3, 1, 0, 0, 8);
    // R3 not-equal, raw mode (R4)
    cyc(1, 4, 3'b000, 0, 0, 0, 0, 3);
    cyc(0, 0, 0, 4, 1, 0, 0, 3);
    cyc(0, 0, 0, 6, 1, 0, 0, 4);
    cyc(0, 0, 0, 3, 1, 0, 0, 3);
    // R3 equal, unit mode
    cyc(1, 4, 3'b011, 0, 0, 0, 0, 3);
    cyc(0, 0, 0, 4, 1, 0, 0, 3);
    cyc(0, 0, 0, 5, 1, 0, 0, 3);
    cyc(0, 0, 0, 3, 1, 0, 0, 3);
    // R3 greater-or-equal, raw
    cyc(1, 4, 3'b100, 0, 0, 0, 0, 3);
    cyc(0, 0, 0, 3, 1, 0, 0, 3);
    cyc(0, 0, 0, 4, 1, 0, 0, 3);
    cyc(0, 0, 0, 200, 1, 0, 0, 4);
    // R3 less-than, unit
    cyc(1, 4, 3'b111, 0, 0, 0, 0, 3);
    cyc(0, 0, 0, 3, 1, 0, 0, 3);
    cyc(0, 0, 0, 4, 1, 0, 0, 3);
    cyc(0, 0, 0, 0, 1, 0, 0, 3);
    cyc(0, 0, 0, 5, 1, 0, 0, 3);
    // R5: saturating write, then boundary at max
    cyc(1, 4000, 3'b100, 0, 0, 0, 0, 5);
    cyc(0, 0, 0, 254, 1, 0, 0, 5);
    cyc(0, 0, 0, 255, 1, 0, 0, 5);
    cyc(1, 255, 3'b101, 0, 0, 0, 0, 5);
    cyc(0, 0, 0, 255, 1, 0, 0, 5);
    cyc(1, 256, 3'b101, 0, 0, 0, 0, 5);
    // R9: disabled
    cyc(0, 0, 0, 255, 0, 0, 0, 9);
    cyc(0, 0, 0, 255, 0, 0, 0, 9);
    // R11: clear beats increment
    cyc(0, 0, 0, 255, 1, 1, 0, 11);
    // R10: raw counting through wrap, flag held
    cyc(1, 0, 3'b000, 0, 0, 0, 0, 10);
    for (int i = 0; i < 270; i++) cyc(0, 0, 0, 255, 1, 0, 0, 10);
    cyc(0, 0, 0, 0, 0, 0, 1, 10);
    // R11: clear keeps overflow flag as is
    cyc(0, 0, 0, 0, 1, 1, 0, 11);
    // R10: clear pulse held through next wrap, set wins
    for (int i = 0; i < 270; i++) cyc(0, 0, 0, 255, 1, 0, 1, 10);
    cyc(0, 0, 0, 0, 0, 0, 0, 10);
    cyc(0, 0, 0, 0, 0, 0, 1, 10);

    @(negedge clk_i);
    cnt_en_i = 1'b0; cfg_we_i = 1'b0; ovf_clr_i = 1'b0;
    repeat (3) @(posedge clk_i);
    #2;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule